// File: doc/BRIEF.md
# Receive Character Queue with Threshold Flags

This block sits between a serial deserializer and a bus-readable receive data register. Each completed character arrives from the deserializer with a one-cycle valid pulse. The block stores it, and the oldest stored character is always presented on a read-data output. A read strobe from the bus side consumes that front character and frees exactly one location.

Status flags report the buffer state:
- not-empty: at least one character is stored.
- full: every location allowed by the current mode is occupied.
- threshold: the stored count has reached a programmed level. The character held at the front counts as one entry.
- overrun: a one-cycle pulse raised when an arriving character cannot be stored.

A flush request discards all stored content. A mode input selects between a queue of `DEPTH` entries and a single holding register with a capacity of one.

Top module: `rx_char_queue`

## Requirements
- R1: After reset, not_empty, full, thr_hit and overrun are all 0.
- R2: Characters leave in arrival order. While not_empty is 1, rd_data shows the oldest stored character. Each read strobe while not_empty is 1 removes exactly one character.
- R3: not_empty is 1 while any character is stored and returns to 0 only when the last one has been read or flushed.
- R4: full is 1 exactly when the stored count equals the capacity. The capacity is DEPTH (8) when fifo_mode is 1 and 1 when fifo_mode is 0.
- R5: thr_code selects a level: 0 gives 1, 1 gives DEPTH/4 (2), 2 gives DEPTH/2 (4), 3 gives 3*DEPTH/4 (6), and 4 to 7 give DEPTH (8). thr_hit is 1 when fifo_mode is 1 and the stored count, including the front character, is at least that level. thr_hit is 0 in register mode.
- R6: In queue mode, a character that arrives while full and without a same-cycle read is dropped. overrun then pulses high for the one cycle after that clock edge, and the stored characters and their order are unchanged.
- R7: In register mode, a character that arrives while the single register still holds an unread character is dropped, overrun pulses, and the held character stays on rd_data.
- R8: An arrival and a read in the same cycle while full are both performed: the front character leaves, the new one is stored, the count stays the same and no overrun is raised.
- R9: A flush empties the buffer within one clock, so not_empty, full and thr_hit are 0 afterwards. A character arriving in the same cycle as the flush is discarded without overrun.
- R10: A read strobe while the buffer is empty has no effect: the flags stay unchanged and a following arrival is the next character presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1: queue of DEPTH entries, 0: single register |
| thr_code | input | 3 | Threshold level select |
| in_valid | input | 1 | Character from deserializer is valid this cycle |
| in_data | input | WIDTH (9) | Received character |
| rd_strobe | input | 1 | Bus read of the front character |
| flush | input | 1 | Discard all stored characters |
| rd_data | output | WIDTH (9) | Oldest stored character |
| not_empty | output | 1 | At least one character stored |
| full | output | 1 | Stored count equals capacity |
| thr_hit | output | 1 | Stored count at or above the selected level |
| overrun | output | 1 | One-cycle pulse after a dropped arrival |

## Verification
The bench drives the buffer exactly to capacity and then pushes one more character. A design that overwrote a slot or moved a pointer on a dropped character would present the wrong character at a later read. The same edge is tested with a simultaneous read: a design that checked fullness without considering the read would falsely drop the character and pulse overrun. Every threshold code is tested at the count where its flag should first rise, which exposes a design that forgot to count the front character or compared with a strict inequality. Flush with a same-cycle arrival, reads of an empty buffer and register-mode overrun are also covered. An implementation that left a stale character in place or raised overrun from the full flag alone would fail these checks.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Threshold level for a code; fractions of the depth, never below one.
  function automatic int unsigned thr_level(input logic [2:0] code,
                                            input int unsigned depth);
    int unsigned lvl;
    case (code)
      3'd0:    lvl = 1;
      3'd1:    lvl = depth / 4;
      3'd2:    lvl = depth / 2;
      3'd3:    lvl = (3 * depth) / 4;
      default: lvl = depth;
    endcase
    if (lvl == 0) lvl = 1;
    return lvl;
  endfunction

  // Ring successor of a pointer.
  function automatic int unsigned ring_next(input int unsigned ptr,
                                            input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/rxq_ptr.sv
module rxq_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= '0;
    else if (clr)  ptr <= '0;
    else if (adv)  ptr <= PTR_W'(rxq_pkg::ring_next(int'(ptr), DEPTH));
  end
endmodule

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 9,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot[i] <= '0;
      else if (we && wr_ptr == PTR_W'(i))  slot[i] <= wdata;
    end
  end

  assign rdata = slot[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [2:0]       thr_code,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic             wr_en,
  output logic             rd_en,
  output logic             clr,
  output logic             ovr_evt,
  output logic [CNT_W-1:0] cnt,
  output logic             not_empty,
  output logic             full,
  output logic             thr_hit,
  output logic             overrun
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

  logic [CNT_W-1:0] cap;
  logic [CNT_W-1:0] level;
  logic [CNT_W-1:0] cnt_nx;
  logic             ovr_q;

  assign cap       = fifo_mode ? DEPTH_C : ONE_C;
  assign level     = CNT_W'(rxq_pkg::thr_level(thr_code, DEPTH));
  assign not_empty = (cnt != '0);
  assign full      = (cnt >= cap);
  assign thr_hit   = fifo_mode && (cnt >= level);

  assign clr     = flush;
  assign rd_en   = pop && not_empty && !flush;
  assign wr_en   = push && !flush && (!full || rd_en);
  assign ovr_evt = push && !flush && full && !rd_en;

  always_comb begin
    if (flush)               cnt_nx = '0;
    else if (wr_en && !rd_en) cnt_nx = cnt + ONE_C;
    else if (rd_en && !wr_en) cnt_nx = cnt - ONE_C;
    else                      cnt_nx = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ovr_q <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      ovr_q <= ovr_evt;
    end
  end

  assign overrun = ovr_q;

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= DEPTH_C);

  // R6
  drop_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (cnt == $past(cnt)) && overrun);

  // R8
  full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop && !flush) |=> (cnt == $past(cnt)) && !overrun);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !not_empty && !overrun);

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!not_empty && pop && !push && !flush) |=> !not_empty);

  // R2
  single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en) |=> cnt == $past(cnt) - ONE_C);
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic [2:0]       thr_code,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  input  logic             rd_strobe,
  input  logic             flush,
  output logic [WIDTH-1:0] rd_data,
  output logic             not_empty,
  output logic             full,
  output logic             thr_hit,
  output logic             overrun
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             wr_en, rd_en, clr, ovr_evt;
  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .thr_code(thr_code),
    .push(in_valid), .pop(rd_strobe), .flush(flush),
    .wr_en(wr_en), .rd_en(rd_en), .clr(clr), .ovr_evt(ovr_evt), .cnt(cnt),
    .not_empty(not_empty), .full(full), .thr_hit(thr_hit), .overrun(overrun)
  );

  rxq_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(wr_en), .ptr(wr_ptr)
  );

  rxq_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(rd_en), .ptr(rd_ptr)
  );

  rxq_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .wr_ptr(wr_ptr), .wdata(in_data),
    .rd_ptr(rd_ptr), .rdata(rd_data)
  );

  // R7
  reg_mode_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && ovr_evt) |-> not_empty);

  // R6
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> !wr_en);

  // R3
  ne_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (not_empty && !rd_strobe && !flush) |=> not_empty);
endmodule

// File: tb/rx_char_queue_test.sv
module rx_char_queue_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_mode = 1'b1;
  logic [2:0] thr_code = 3'd0;
  logic       in_valid = 1'b0;
  logic [8:0] in_data = '0;
  logic       rd_strobe = 1'b0;
  logic       flush = 1'b0;
  logic [8:0] rd_data;
  logic       not_empty, full, thr_hit, overrun;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          done = 0;
  string       tag = "R1";
  logic [8:0]  sb[$];
  bit          exp_ovr = 0;

  always #2 clk = ~clk;

  rx_char_queue uut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .thr_code(thr_code),
    .in_valid(in_valid), .in_data(in_data), .rd_strobe(rd_strobe),
    .flush(flush), .rd_data(rd_data), .not_empty(not_empty), .full(full),
    .thr_hit(thr_hit), .overrun(overrun)
  );

  function automatic int lvl_of(input logic [2:0] c);
    int t[8] = '{1, 2, 4, 6, 8, 8, 8, 8};
    return t[c];
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compare outputs with the scoreboard after each edge.
  task automatic monitor();
    int cap = fifo_mode ? 8 : 1;
    chk("not_empty", int'(not_empty), int'(sb.size() != 0));
    chk("full", int'(full), int'(sb.size() >= cap));
    chk("thr_hit", int'(thr_hit), int'(fifo_mode && sb.size() >= lvl_of(thr_code)));
    chk("overrun", int'(overrun), int'(exp_ovr));
    if (sb.size() != 0) chk("rd_data", int'(rd_data), int'(sb[0]));
  endtask

  // Driver: one cycle of stimulus, scoreboard updated per the requirements.
  task automatic step(input bit p, input logic [8:0] d, input bit r, input bit f);
    int  cap;
    bit  full_m, rd, wr;
    @(negedge clk);
    in_valid = p; in_data = d; rd_strobe = r; flush = f;
    cap    = fifo_mode ? 8 : 1;
    full_m = sb.size() >= cap;
    rd     = r && sb.size() != 0 && !f;
    wr     = p && !f && (!full_m || rd);
    exp_ovr = p && !f && full_m && !rd;
    if (f) sb.delete();
    else begin
      if (rd) void'(sb.pop_front());
      if (wr) sb.push_back(d);
    end
    @(posedge clk); #1;
    in_valid = 0; rd_strobe = 0; flush = 0;
    monitor();
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tag = "R1"; monitor();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; monitor();

    // R3 R5: fill with threshold at 4
    thr_code = 3'd2;
    tag = "R3";
    for (int i = 0; i < 5; i++) step(1, 9'(16 + i), 0, 0);
    // R2: reads in order
    tag = "R2";
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    // R4: fill to capacity
    tag = "R4";
    for (int i = 0; i < 5; i++) step(1, 9'(256 + i), 0, 0);
    // R6: drop while full
    tag = "R6";
    step(1, 9'h1AA, 0, 0);
    step(1, 9'h0CC, 0, 0);
    step(0, 0, 0, 0);
    // R8: read and arrival together at full
    tag = "R8";
    step(1, 9'h155, 1, 0);
    step(1, 9'h0AB, 1, 0);
    // R2 drain
    tag = "R2";
    for (int i = 0; i < 8; i++) step(0, 0, 1, 0);
    // R10: read on empty
    tag = "R10";
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    step(1, 9'h033, 0, 0);
    step(0, 0, 1, 0);

    // R5: every code at its rising count
    tag = "R5";
    for (int c = 0; c < 8; c++) begin
      thr_code = 3'(c);
      for (int k = 0; k < lvl_of(3'(c)); k++) step(1, 9'(c * 10 + k), 0, 0);
      step(0, 0, 1, 0);
      step(0, 0, 0, 1);
    end

    // R9: flush with same-cycle arrival
    tag = "R9";
    thr_code = 3'd0;
    step(1, 9'h011, 0, 0);
    step(1, 9'h022, 0, 0);
    step(1, 9'h044, 0, 1);
    step(1, 9'h088, 0, 0);
    step(0, 0, 1, 0);

    // R7: register mode
    tag = "R7";
    fifo_mode = 1'b0;
    step(0, 0, 0, 0);
    step(1, 9'h101, 0, 0);
    step(1, 9'h102, 0, 0);
    step(0, 0, 0, 0);
    tag = "R8";
    step(1, 9'h103, 1, 0);
    tag = "R7";
    step(0, 0, 1, 0);
    step(1, 9'h104, 0, 0);
    step(1, 9'h105, 0, 0);
    step(0, 0, 1, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule